// File: doc/BRIEF.md
# Fuse Array Command Controller

This block is a register-mapped front end for a one-time-programmable fuse array. Software drives it with plain register writes. It writes a command code, a row address and one or two data words, then raises a start bit. It polls a done flag in the status register, and finally clears the start bit. The fuse array is a behavioural model held inside the block. A row is one or two 32-bit words wide, chosen at elaboration time.

Two command codes act on the array. Read (code 0x00) copies a row into the read-data registers. Program (code 0x08) sets fuse bits by OR-ing the write-data words into the row, so a fuse bit can never be cleared. Programming changes the array only while the permission input is high. The time a program command takes grows with the number of one bits being written. A fixed base count is added to a per-bit count, so an all-ones row is the slowest case. Commands are accepted only after the CPU-enable bit in the mode register has been set.

Top module: `fuse_cmd_ctrl`

## Requirements
- R1: After reset the mode, command, start, status, address, write-data and read-data registers all read as 0, and every fuse bit is 0.
- R2: A rising edge of start (bit 0 of offset 0x08) launches a command only when mode bit 0 (offset 0x00) is 1. With mode bit 0 at 0, done never sets.
- R3: Read (command 0x00) loads the row selected by the low log2(ROWS) bits of the address register (offset 0x28) into read data. Word 0 is at 0x10 and word 1 is at 0x5C. Done (status offset 0x0C, bit 1) sets READ_LAT cycles after the launching write.
- R4: Program (command 0x08) ORs the write words (word 0 at 0x2C, word 1 at 0x64) into the addressed row. Bits already set stay set.
- R5: Program sets done BASE_LAT + PER_BIT_LAT × (number of one bits across the row's write words) cycles after the launching write. With the defaults this is 4 + ones.
- R6: A program command launched while the permission input is low still sets done with the R5 latency, but it leaves the array unchanged.
- R7: Writing 0 to start clears done. Writing 1 while start is already 1 launches nothing: done stays set and the array is untouched.
- R8: Only the low 6 bits of a command write are kept. Only the low 16 bits of an address write are kept. The upper bits are ignored both in readback and in decoding.
- R9: With two-word rows (ROW_WORDS=2), word 1 is written at 0x64 and read at 0x5C, and both words take part in read, program and latency.
- R10: Any other command code sets done after BASE_LAT cycles and leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access in this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| progAllow | input | 1 | Program permission from the unlock logic, sampled at launch |

## Verification
Program commands are tried with three kinds of data. An all-ones word separates the per-bit latency term from the base term. Sparse random patterns check that latency counts the ones across both words. Overlapping patterns on the same row show OR accumulation as distinct from overwrite. The same programs are repeated with permission low, which separates "done but unchanged" from a real write. Command and address writes carry junk in their upper bits, and the address is random over 16 bits, which exercises truncation and row wrap. A repeated start write while start is still high shows that launch needs an edge, not a level.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam int CMD_W = 6;

  localparam logic [7:0] OFS_MODE   = 8'h00;
  localparam logic [7:0] OFS_CMD    = 8'h04;
  localparam logic [7:0] OFS_START  = 8'h08;
  localparam logic [7:0] OFS_STATUS = 8'h0C;
  localparam logic [7:0] OFS_RD0    = 8'h10;
  localparam logic [7:0] OFS_ADDR   = 8'h28;
  localparam logic [7:0] OFS_WR0    = 8'h2C;
  localparam logic [7:0] OFS_RD1    = 8'h5C;
  localparam logic [7:0] OFS_WR1    = 8'h64;

  localparam logic [CMD_W-1:0] CODE_READ = 6'h00;
  localparam logic [CMD_W-1:0] CODE_PROG = 6'h08;

  typedef enum logic [1:0] {OP_READ, OP_PROG, OP_OTHER} opKind_e;

  typedef struct packed {
    logic latchOp;
    logic finishRead;
    logic finishProg;
  } fuseStrobe_t;

  function automatic logic [7:0] wrOfs(int w);
    return (w == 0) ? OFS_WR0 : OFS_WR1;
  endfunction
endpackage

// File: rtl/fuse_ctrl.sv
module fuse_ctrl
  import fuse_pkg::*;
#(
  parameter int BASE_LAT    = 4,
  parameter int PER_BIT_LAT = 1,
  parameter int READ_LAT    = 3,
  parameter int ONES_W      = 7,
  parameter int CNT_W       = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [7:0]        busAddr,
  input  logic [CMD_W-1:0]  busWlow,
  input  logic [ONES_W-1:0] onesNow,
  output logic              modeEn,
  output logic [CMD_W-1:0]  cmdReg,
  output logic              startReg,
  output logic              doneFlag,
  output fuseStrobe_t       strobe
);
  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] latNext;
  opKind_e          kindNow, kindQ;
  logic             wrMode, wrCmd, wrStart, launch, lastTick;

  assign wrMode  = busSel && busWr && (busAddr == OFS_MODE);
  assign wrCmd   = busSel && busWr && (busAddr == OFS_CMD);
  assign wrStart = busSel && busWr && (busAddr == OFS_START);
  assign launch  = wrStart && busWlow[0] && !startReg && modeEn && !busy;
  assign lastTick = busy && (cnt == CNT_W'(1));

  always_comb begin
    if (cmdReg == CODE_READ)      kindNow = OP_READ;
    else if (cmdReg == CODE_PROG) kindNow = OP_PROG;
    else                          kindNow = OP_OTHER;
  end

  always_comb begin
    case (kindNow)
      OP_READ: latNext = CNT_W'(READ_LAT);
      OP_PROG: latNext = CNT_W'(BASE_LAT) + CNT_W'(PER_BIT_LAT) * CNT_W'(onesNow);
      default: latNext = CNT_W'(BASE_LAT);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeEn   <= 1'b0;
      cmdReg   <= '0;
      startReg <= 1'b0;
      doneFlag <= 1'b0;
      busy     <= 1'b0;
      cnt      <= '0;
      kindQ    <= OP_OTHER;
    end else begin
      if (wrMode)  modeEn   <= busWlow[0];
      if (wrCmd)   cmdReg   <= busWlow;
      if (wrStart) startReg <= busWlow[0];
      if (wrStart && !busWlow[0]) doneFlag <= 1'b0;
      if (launch) begin
        busy     <= 1'b1;
        cnt      <= latNext;
        kindQ    <= kindNow;
        doneFlag <= 1'b0;
      end else if (busy) begin
        cnt <= cnt - CNT_W'(1);
        if (lastTick) begin
          busy     <= 1'b0;
          doneFlag <= 1'b1;
        end
      end
    end
  end

  assign strobe.latchOp    = launch;
  assign strobe.finishRead = lastTick && (kindQ == OP_READ);
  assign strobe.finishProg = lastTick && (kindQ == OP_PROG);

  p_busy_done_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && doneFlag));
  p_launch_needs_mode_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(modeEn));
  p_cnt_live_r5: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (cnt != '0));
  p_done_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrStart && !busWlow[0] && !lastTick) |=> !doneFlag);
  p_no_retrigger_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrStart && startReg) |=> !$rose(busy));
endmodule

// File: rtl/fuse_dp.sv
module fuse_dp
  import fuse_pkg::*;
#(
  parameter int ROWS      = 16,
  parameter int ROW_WORDS = 2,
  parameter int ADDR_W    = 16,
  parameter int ONES_W    = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [7:0]         busAddr,
  input  logic [31:0]        busWdata,
  input  logic               progAllow,
  input  fuseStrobe_t        strobe,
  output logic [ADDR_W-1:0]  addrReg,
  output logic [1:0][31:0]   wrWords,
  output logic [1:0][31:0]   rdWords,
  output logic [ONES_W-1:0]  onesNow
);
  localparam int ROW_BITS = 32 * ROW_WORDS;
  localparam int IDX_W    = (ROWS > 1) ? $clog2(ROWS) : 1;

  logic [31:0]         wrReg [ROW_WORDS];
  logic [ROW_BITS-1:0] curData, opData, rdataQ;
  logic [ROW_BITS-1:0] fuseRow [ROWS];
  logic [IDX_W-1:0]    opIdx;
  logic                opAllow;
  logic                busWrite;

  assign busWrite = busSel && busWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      for (int w = 0; w < ROW_WORDS; w++) wrReg[w] <= '0;
    end else begin
      if (busWrite && busAddr == OFS_ADDR) addrReg <= busWdata[ADDR_W-1:0];
      for (int w = 0; w < ROW_WORDS; w++)
        if (busWrite && busAddr == wrOfs(w)) wrReg[w] <= busWdata;
    end
  end

  always_comb begin
    curData = '0;
    wrWords = '0;
    rdWords = '0;
    for (int w = 0; w < ROW_WORDS; w++) begin
      curData[w*32 +: 32] = wrReg[w];
      wrWords[w]          = wrReg[w];
      rdWords[w]          = rdataQ[w*32 +: 32];
    end
  end

  always_comb begin
    onesNow = '0;
    for (int b = 0; b < ROW_BITS; b++) onesNow = onesNow + ONES_W'(curData[b]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opIdx   <= '0;
      opData  <= '0;
      opAllow <= 1'b0;
      rdataQ  <= '0;
      for (int r = 0; r < ROWS; r++) fuseRow[r] <= '0;
    end else begin
      if (strobe.latchOp) begin
        opIdx   <= addrReg[IDX_W-1:0];
        opData  <= curData;
        opAllow <= progAllow;
      end
      if (strobe.finishRead) rdataQ <= fuseRow[opIdx];
      if (strobe.finishProg && opAllow) fuseRow[opIdx] <= fuseRow[opIdx] | opData;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_rowChk
    p_fuse_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
      (fuseRow[r] & $past(fuseRow[r])) == $past(fuseRow[r]));
    p_locked_r6: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.finishProg && !opAllow) |=> $stable(fuseRow[r]));
    p_read_keeps_r3: assert property (@(posedge clk) disable iff (!rstN)
      strobe.finishRead |=> $stable(fuseRow[r]));
  end
endmodule

// File: rtl/fuse_cmd_ctrl.sv
module fuse_cmd_ctrl
  import fuse_pkg::*;
#(
  parameter int ROW_WORDS   = 2,
  parameter int ROWS        = 16,
  parameter int ADDR_W      = 16,
  parameter int BASE_LAT    = 4,
  parameter int PER_BIT_LAT = 1,
  parameter int READ_LAT    = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWr,
  input  logic [7:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic        progAllow
);
  localparam int ROW_BITS = 32 * ROW_WORDS;
  localparam int ONES_W   = $clog2(ROW_BITS + 1);
  localparam int MAX_LAT  = BASE_LAT + PER_BIT_LAT * ROW_BITS + READ_LAT;
  localparam int CNT_W    = $clog2(MAX_LAT + 1);

  fuseStrobe_t        strobe;
  logic               modeEn, startReg, doneFlag;
  logic [CMD_W-1:0]   cmdReg;
  logic [ADDR_W-1:0]  addrReg;
  logic [1:0][31:0]   wrWords, rdWords;
  logic [ONES_W-1:0]  onesNow;

  fuse_ctrl #(
    .BASE_LAT(BASE_LAT), .PER_BIT_LAT(PER_BIT_LAT), .READ_LAT(READ_LAT),
    .ONES_W(ONES_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWlow(busWdata[CMD_W-1:0]), .onesNow(onesNow), .modeEn(modeEn),
    .cmdReg(cmdReg), .startReg(startReg), .doneFlag(doneFlag), .strobe(strobe)
  );

  fuse_dp #(
    .ROWS(ROWS), .ROW_WORDS(ROW_WORDS), .ADDR_W(ADDR_W), .ONES_W(ONES_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .progAllow(progAllow), .strobe(strobe),
    .addrReg(addrReg), .wrWords(wrWords), .rdWords(rdWords), .onesNow(onesNow)
  );

  always_comb begin
    case (busAddr)
      OFS_MODE:   busRdata = {31'b0, modeEn};
      OFS_CMD:    busRdata = {{(32-CMD_W){1'b0}}, cmdReg};
      OFS_START:  busRdata = {31'b0, startReg};
      OFS_STATUS: busRdata = {30'b0, doneFlag, 1'b0};
      OFS_ADDR:   busRdata = {{(32-ADDR_W){1'b0}}, addrReg};
      OFS_WR0:    busRdata = wrWords[0];
      OFS_RD0:    busRdata = rdWords[0];
      OFS_WR1:    busRdata = wrWords[1];
      OFS_RD1:    busRdata = rdWords[1];
      default:    busRdata = '0;
    endcase
  end

  p_launch_edge_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchOp |-> !startReg);
  p_strobe_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.latchOp, strobe.finishRead, strobe.finishProg}));
endmodule

// File: tb/fuse_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module fuse_cmd_ctrl_tb;
  localparam int BASE = 4;
  localparam int RLAT = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWr = 1'b0, progAllow = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;

  int checks = 0;
  int fails = 0;
  logic [63:0] model [16];

  always #2.5 clk = ~clk;

  fuse_cmd_ctrl u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .progAllow(progAllow)
  );

  function automatic int ones32(logic [31:0] v);
    int n = 0;
    for (int b = 0; b < 32; b++) n += int'(v[b]);
    return n;
  endfunction

  function automatic int progLat(logic [31:0] d0, logic [31:0] d1);
    return BASE + ones32(d0) + ones32(d1);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [31:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1;
    d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic runCmd(input logic [31:0] cmd, input logic [31:0] addr,
                        input logic [31:0] d0, input logic [31:0] d1, output int lat);
    logic [31:0] s;
    busWrite(8'h04, cmd);
    busWrite(8'h28, addr);
    busWrite(8'h2C, d0);
    busWrite(8'h64, d1);
    busWrite(8'h08, 32'h1);
    lat = 0;
    peek(8'h0C, s);
    while (!s[1] && lat < 500) begin
      @(negedge clk);
      lat++;
      peek(8'h0C, s);
    end
    busWrite(8'h08, 32'h0);
    peek(8'h0C, s);
    check(s[1] == 1'b0, "R7 done clears on start=0", 64'(s), 64'h0);
  endtask

  task automatic readRow(input logic [31:0] addr, output logic [63:0] v, output int lat);
    logic [31:0] w0, w1;
    runCmd(32'h0, addr, 32'h0, 32'h0, lat);
    peek(8'h10, w0);
    peek(8'h5C, w1);
    v = {w1, w0};
  endtask

  task automatic progRow(input logic [31:0] cmd, input logic [31:0] addr,
                         input logic [31:0] d0, input logic [31:0] d1,
                         input logic allow, output int lat);
    progAllow = allow;
    runCmd(cmd, addr, d0, d1, lat);
    if (allow) model[addr[3:0]] = model[addr[3:0]] | {d1, d0};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] s;
    logic [63:0] v;
    int lat;
    void'($urandom(32'h5eed_1234));
    for (int r = 0; r < 16; r++) model[r] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(8'h00, s); check(s == 0, "R1 mode reset", 64'(s), 0);
    peek(8'h0C, s); check(s == 0, "R1 status reset", 64'(s), 0);
    peek(8'h28, s); check(s == 0, "R1 address reset", 64'(s), 0);
    peek(8'h10, s); check(s == 0, "R1 read word0 reset", 64'(s), 0);
    peek(8'h5C, s); check(s == 0, "R1 read word1 reset", 64'(s), 0);

    // R2 no launch while mode bit 0 is clear
    busWrite(8'h04, 32'h0);
    busWrite(8'h08, 32'h1);
    repeat (20) @(negedge clk);
    peek(8'h0C, s); check(s[1] == 1'b0, "R2 gated by mode", 64'(s), 0);
    busWrite(8'h08, 32'h0);
    busWrite(8'h00, 32'h1);

    // R8 field truncation
    busWrite(8'h04, 32'hFFFF_FFC8);
    peek(8'h04, s); check(s == 32'h08, "R8 command 6 bits", 64'(s), 64'h08);
    busWrite(8'h28, 32'hABCD_1234);
    peek(8'h28, s); check(s == 32'h1234, "R8 address 16 bits", 64'(s), 64'h1234);

    // R5 all-ones word is slowest; R4/R9 two words
    progRow(32'h08, 32'h3, 32'hFFFF_FFFF, 32'h0, 1'b1, lat);
    check(lat == BASE + 32, "R5 all-ones latency", 64'(lat), 64'(BASE + 32));
    readRow(32'h3, v, lat);
    check(v == model[3], "R3 read row 3", v, model[3]);
    check(lat == RLAT, "R3 read latency", 64'(lat), 64'(RLAT));

    // R4 OR accumulation, R9 second word
    progRow(32'h08, 32'h5, 32'h0000_00F0, 32'h8000_0001, 1'b1, lat);
    check(lat == progLat(32'hF0, 32'h8000_0001), "R9 latency counts both words", 64'(lat), 64'(BASE + 6));
    progRow(32'h08, 32'h5, 32'h0000_000F, 32'h0, 1'b1, lat);
    readRow(32'h5, v, lat);
    check(v == 64'h8000_0001_0000_00FF, "R4 OR accumulates", v, 64'h8000_0001_0000_00FF);
    progRow(32'h08, 32'h5, 32'h0, 32'h0, 1'b1, lat);
    check(lat == BASE, "R5 zero-ones latency", 64'(lat), 64'(BASE));
    readRow(32'h5, v, lat);
    check(v == 64'h8000_0001_0000_00FF, "R4 zero program keeps bits", v, 64'h8000_0001_0000_00FF);

    // R6 permission low
    progRow(32'h08, 32'h7, 32'h0000_AAAA, 32'h1, 1'b0, lat);
    check(lat == BASE + 9, "R6 locked latency", 64'(lat), 64'(BASE + 9));
    readRow(32'h7, v, lat);
    check(v == 64'h0, "R6 locked row unchanged", v, 64'h0);

    // R7 level on start does not relaunch
    progAllow = 1'b1;
    busWrite(8'h04, 32'h08);
    busWrite(8'h28, 32'h9);
    busWrite(8'h2C, 32'h1);
    busWrite(8'h64, 32'h0);
    busWrite(8'h08, 32'h1);
    repeat (20) @(negedge clk);
    peek(8'h0C, s); check(s[1] == 1'b1, "R7 done after edge", 64'(s), 64'h2);
    model[9] = 64'h1;
    busWrite(8'h2C, 32'hF0);
    busWrite(8'h08, 32'h1);
    peek(8'h0C, s); check(s[1] == 1'b1, "R7 no relaunch keeps done", 64'(s), 64'h2);
    repeat (60) @(negedge clk);
    busWrite(8'h08, 32'h0);
    readRow(32'h9, v, lat);
    check(v == 64'h1, "R7 level start ignored", v, 64'h1);

    // R10 unknown command
    runCmd(32'h03, 32'h3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, lat);
    check(lat == BASE, "R10 other command latency", 64'(lat), 64'(BASE));
    readRow(32'h3, v, lat);
    check(v == model[3], "R10 array unchanged", v, model[3]);

    // R3 address wrap onto low bits
    readRow(32'h0013, v, lat);
    check(v == model[3], "R3 address wraps to row 3", v, model[3]);

    // Random mix
    for (int i = 0; i < 60; i++) begin
      logic [31:0] a, d0, d1, cmd;
      a = $urandom & 32'hFFFF;
      if ($urandom % 2 == 0) begin
        d0 = $urandom & $urandom & $urandom;
        d1 = $urandom & $urandom & $urandom;
        cmd = ($urandom & 32'hFFFF_FFC0) | 32'h08;
        progRow(cmd, a, d0, d1, ($urandom % 4) != 0, lat);
        check(lat == progLat(d0, d1), "R5 random program latency", 64'(lat), 64'(progLat(d0, d1)));
      end else begin
        readRow(a, v, lat);
        check(v == model[a[3:0]], "R4 random read matches model", v, model[a[3:0]]);
        check(lat == RLAT, "R3 random read latency", 64'(lat), 64'(RLAT));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule